// File: doc/BRIEF.md
# Averaging ADC Conversion Sequencer

This block is a byte-wide register-mapped controller placed in front of a 10-bit successive-approximation converter core. Software enables it, picks a channel and an averaging depth, and either starts a conversion directly or arms a hardware path. On the hardware path, an edge on an external trigger loads a countdown timer. When the timer reaches zero, one averaged conversion runs. The two paths keep separate configuration registers, separate result registers and separate completion interrupts. A single averaging engine serves both paths, so only one conversion is in progress at any time.

The core is reached through a request stream and a response strobe. The request side follows valid/ready rules. `core_req_valid` is raised with a channel on `core_req_chan`, and both stay fixed until a cycle in which `core_req_ready` is high; that cycle completes the transfer. The core may hold `core_req_ready` low for as long as it needs. The response side has no back-pressure. `core_res_valid` is a one-cycle strobe, and the block accepts it only while it is waiting for a sample. A response that arrives at any other time is dropped. Multiplexer, buffer, pull-up and current-sense controls are not modelled; the block only drives their enable bits on `pad_en`.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, every register at addresses 0x00 to 0x0A reads 0x00, both interrupts and `core_req_valid` are low, and `pad_en` is 0.
- R2: Address 0x00 (control) reads back the byte last written. `pad_en` is {bit7 current sense, bit6 buffer, bit5 supply select, bit3 pull-up} of control when bit0 (enable) is 1, and 0 otherwise. Writing 0x00 clears every enable.
- R3: A control write with bit0 and bit2 (start) both set, made while idle, starts a software conversion. It issues 1, 4, 8 or 16 core requests, chosen by bits 6:5 (00, 01, 10, 11) of address 0x01, on the channel in bits 4:0 of 0x01. Status at 0x04 reads bit0 = 1 throughout the conversion.
- R4: The software result is the floor of the sum of the returned codes divided by the sample count. Address 0x05 holds result bits 7:0 and 0x06 holds bits 9:8.
- R5: When a software conversion ends, the start bit in control reads 0 and `irq_sw` is high for exactly one cycle, in the first cycle the new result is readable.
- R6: For channels 0x1C to 0x1F, a software conversion also averages the second code, and that average is readable at 0x09 (low) and 0x0A (high). For any other channel, 0x09 and 0x0A keep their previous value.
- R7: With control bits 0 and 1 set, an edge of `hw_trig` loads the timer from 0x03. The edge is rising when bit4 is 0 and falling when bit4 is 1. More than that many cycles later, one averaged conversion runs on the channel and depth in 0x02. Its result lands in 0x07/0x08 and `irq_hw` pulses; 0x05/0x06 are unchanged.
- R8: The trigger edge of the unselected polarity starts nothing.
- R9: A hardware trigger while 0x02 selects a channel from 0x1C to 0x1F issues no core request and raises no interrupt.
- R10: A start write or a timer expiry that arrives while a conversion is in progress is ignored. The start bit stays 0, and the running conversion issues no extra requests.
- R11: Clearing control bit0 aborts a running conversion. Status reads idle on the next cycle, no interrupt follows, the result registers are unchanged, and later core responses are dropped.
- R12: `core_req_valid` and `core_req_chan` hold steady while `core_req_ready` is low, and the average stays correct under any pattern of ready stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational from bus_addr) |
| hw_trig | input | 1 | Asynchronous external trigger |
| core_req_valid | output | 1 | Conversion request to the core |
| core_req_ready | input | 1 | Core accepts the request |
| core_req_chan | output | 5 | Channel of the request |
| core_res_valid | input | 1 | One-cycle strobe: sample codes are valid |
| core_res_code | input | 10 | Primary sample code |
| core_res_code2 | input | 10 | Second sample code (double-measurement channels) |
| irq_sw | output | 1 | Software conversion complete pulse |
| irq_hw | output | 1 | Hardware conversion complete pulse |
| pad_en | output | 4 | Analog enables {current sense, buffer, supply select, pull-up} |

## Verification
The hardest situations to reach are requests that collide with work already in flight: a start write, or a second timer expiry, while the engine is still collecting samples, and a disable in the middle of a conversion while a core response is still pending. The bench produces the first case with a 16-sample hardware conversion and a zero timer, under a stalling ready pattern. It then issues a start write and a fresh trigger edge inside that window. For the abort, the bench writes control to zero a few cycles after a start and lets the model core's response arrive after the engine has gone idle. The bench then runs a clean conversion to show that no stale state remains.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int ADDR_W = 4;
  localparam int CHAN_W = 5;
  localparam int AVG_LOG2_MAX = 4;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'h0;
  localparam logic [ADDR_W-1:0] A_SWCFG = 4'h1;
  localparam logic [ADDR_W-1:0] A_HWCFG = 4'h2;
  localparam logic [ADDR_W-1:0] A_TIMER = 4'h3;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'h4;
  localparam logic [ADDR_W-1:0] A_SWLO  = 4'h5;
  localparam logic [ADDR_W-1:0] A_SWHI  = 4'h6;
  localparam logic [ADDR_W-1:0] A_HWLO  = 4'h7;
  localparam logic [ADDR_W-1:0] A_HWHI  = 4'h8;
  localparam logic [ADDR_W-1:0] A_X2LO  = 4'h9;
  localparam logic [ADDR_W-1:0] A_X2HI  = 4'hA;

  // control bit positions
  localparam int CB_EN    = 0;
  localparam int CB_TRIG  = 1;
  localparam int CB_START = 2;
  localparam int CB_PULL  = 3;
  localparam int CB_FALL  = 4;
  localparam int CB_SUPP  = 5;
  localparam int CB_BUF   = 6;
  localparam int CB_ISNS  = 7;

  typedef enum logic [1:0] {
    ENG_IDLE, ENG_REQ, ENG_WAIT, ENG_DONE
  } eng_state_e;

  typedef enum logic {
    PATH_SW, PATH_HW
  } path_e;

  // averaging select 00/01/10/11 -> 1/4/8/16 samples
  function automatic logic [2:0] avg_shift(input logic [1:0] sel);
    case (sel)
      2'b00:   return 3'd0;
      2'b01:   return 3'd2;
      2'b10:   return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic is_dual(input logic [CHAN_W-1:0] ch);
    return ch[CHAN_W-1:2] == 3'b111;
  endfunction

endpackage

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
  import adc_seq_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              sw_go,
  input  logic [CHAN_W-1:0] sw_chan,
  input  logic [1:0]        sw_avg,
  input  logic              hw_go,
  input  logic [CHAN_W-1:0] hw_chan,
  input  logic [1:0]        hw_avg,
  output logic              core_req_valid,
  input  logic              core_req_ready,
  output logic [CHAN_W-1:0] core_req_chan,
  input  logic              core_res_valid,
  input  logic [CODE_W-1:0] core_res_code,
  input  logic [CODE_W-1:0] core_res_code2,
  output logic              busy,
  output logic              done,
  output logic              done_path,
  output logic              done_dual,
  output logic [CODE_W-1:0] done_res,
  output logic [CODE_W-1:0] done_res2
);

  localparam int SUM_W = CODE_W + AVG_LOG2_MAX;
  localparam int CNT_W = AVG_LOG2_MAX + 1;

  eng_state_e        state;
  path_e             path_q;
  logic [CHAN_W-1:0] chan_q;
  logic [2:0]        shift_q;
  logic [CNT_W-1:0]  remain_q;
  logic [SUM_W-1:0]  sum_q, sum2_q;
  logic [CODE_W-1:0] res_q, res2_q;

  logic [SUM_W-1:0]  sum_nx, sum2_nx;
  logic [2:0]        sel_shift;

  assign sum_nx    = sum_q + SUM_W'(core_res_code);
  assign sum2_nx   = sum2_q + SUM_W'(core_res_code2);
  assign sel_shift = sw_go ? avg_shift(sw_avg) : avg_shift(hw_avg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ENG_IDLE;
      path_q   <= PATH_SW;
      chan_q   <= '0;
      shift_q  <= '0;
      remain_q <= '0;
      sum_q    <= '0;
      sum2_q   <= '0;
      res_q    <= '0;
      res2_q   <= '0;
    end else if (abort && state != ENG_IDLE) begin
      state <= ENG_IDLE;
    end else begin
      case (state)
        ENG_IDLE: begin
          if (sw_go || hw_go) begin
            path_q   <= sw_go ? PATH_SW : PATH_HW;
            chan_q   <= sw_go ? sw_chan : hw_chan;
            shift_q  <= sel_shift;
            remain_q <= CNT_W'(1) << sel_shift;
            sum_q    <= '0;
            sum2_q   <= '0;
            state    <= ENG_REQ;
          end
        end
        ENG_REQ: begin
          if (core_req_ready) state <= ENG_WAIT;
        end
        ENG_WAIT: begin
          if (core_res_valid) begin
            sum_q  <= sum_nx;
            sum2_q <= sum2_nx;
            if (remain_q == CNT_W'(1)) begin
              res_q  <= CODE_W'(sum_nx >> shift_q);
              res2_q <= CODE_W'(sum2_nx >> shift_q);
              state  <= ENG_DONE;
            end else begin
              remain_q <= remain_q - CNT_W'(1);
              state    <= ENG_REQ;
            end
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assign core_req_valid = (state == ENG_REQ);
  assign core_req_chan  = chan_q;
  assign busy           = (state != ENG_IDLE);
  assign done           = (state == ENG_DONE);
  assign done_path      = path_q;
  assign done_dual      = is_dual(chan_q);
  assign done_res       = res_q;
  assign done_res2      = res2_q;

  // R12: a pending request holds channel and valid until accepted
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req_valid && !core_req_ready && !abort) |=> (core_req_valid && $stable(core_req_chan)));

  // R11: abort returns the engine to idle on the next cycle
  p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !sw_go) |=> !busy);

endmodule

// File: rtl/adc_seq_trigger.sv
module adc_seq_trigger #(
  parameter int TIMER_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_in,
  input  logic               arm_en,
  input  logic               fall_sel,
  input  logic [TIMER_W-1:0] reload,
  output logic               fire
);

  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0]  sync_q;
  logic               prev_q;
  logic               armed_q;
  logic [TIMER_W-1:0] cnt_q;
  logic               lvl, edge_seen;

  assign lvl       = sync_q[SYNC_N-1];
  assign edge_seen = arm_en && (fall_sel ? (prev_q && !lvl) : (!prev_q && lvl));
  assign fire      = arm_en && armed_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], trig_in};
      prev_q <= lvl;
      if (!arm_en) begin
        armed_q <= 1'b0;
      end else if (edge_seen) begin
        armed_q <= 1'b1;
        cnt_q   <= reload;
      end else if (fire) begin
        armed_q <= 1'b0;
      end else if (armed_q) begin
        cnt_q <= cnt_q - TIMER_W'(1);
      end
    end
  end

  // R7: one expiry per loaded edge
  p_fire_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !edge_seen) |=> !fire);

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int CODE_W  = 10,
  parameter int TIMER_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  input  logic               busy,
  input  logic               done,
  input  logic               done_path,
  input  logic               done_dual,
  input  logic [CODE_W-1:0]  done_res,
  input  logic [CODE_W-1:0]  done_res2,
  output logic [7:0]         ctrl,
  output logic [6:0]         sw_cfg,
  output logic [6:0]         hw_cfg,
  output logic [TIMER_W-1:0] timer_val,
  output logic               sw_go,
  output logic               irq_sw,
  output logic               irq_hw
);

  localparam int RB_W = 16;

  logic [7:0]         ctrl_q;
  logic [6:0]         sw_cfg_q, hw_cfg_q;
  logic [TIMER_W-1:0] timer_q;
  logic [CODE_W-1:0]  res_sw_q, res_hw_q, res_x2_q;
  logic               irq_sw_q, irq_hw_q;
  logic               wr_ctrl, fin_sw, fin_hw;
  logic [RB_W-1:0]    rb_sw, rb_hw, rb_x2;

  assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
  assign sw_go   = wr_ctrl && bus_wdata[CB_EN] && bus_wdata[CB_START] && !busy;
  assign fin_sw  = done && (done_path == PATH_SW);
  assign fin_hw  = done && (done_path == PATH_HW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      sw_cfg_q <= '0;
      hw_cfg_q <= '0;
      timer_q  <= '0;
      res_sw_q <= '0;
      res_hw_q <= '0;
      res_x2_q <= '0;
      irq_sw_q <= 1'b0;
      irq_hw_q <= 1'b0;
    end else begin
      if (bus_we) begin
        case (bus_addr)
          A_CTRL: begin
            ctrl_q <= bus_wdata;
            if (!bus_wdata[CB_EN])
              ctrl_q[CB_START] <= 1'b0;
            else if (busy)
              ctrl_q[CB_START] <= ctrl_q[CB_START];
          end
          A_SWCFG: sw_cfg_q <= bus_wdata[6:0];
          A_HWCFG: hw_cfg_q <= bus_wdata[6:0];
          A_TIMER: timer_q  <= TIMER_W'(bus_wdata);
          default: ;
        endcase
      end
      if (fin_sw) begin
        ctrl_q[CB_START] <= 1'b0;
        res_sw_q         <= done_res;
        if (done_dual) res_x2_q <= done_res2;
      end
      if (fin_hw) res_hw_q <= done_res;
      irq_sw_q <= fin_sw;
      irq_hw_q <= fin_hw;
    end
  end

  assign rb_sw = RB_W'(res_sw_q);
  assign rb_hw = RB_W'(res_hw_q);
  assign rb_x2 = RB_W'(res_x2_q);

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_q;
      A_SWCFG: bus_rdata = {1'b0, sw_cfg_q};
      A_HWCFG: bus_rdata = {1'b0, hw_cfg_q};
      A_TIMER: bus_rdata = 8'(timer_q);
      A_STAT:  bus_rdata = {7'b0, busy};
      A_SWLO:  bus_rdata = rb_sw[7:0];
      A_SWHI:  bus_rdata = rb_sw[15:8];
      A_HWLO:  bus_rdata = rb_hw[7:0];
      A_HWHI:  bus_rdata = rb_hw[15:8];
      A_X2LO:  bus_rdata = rb_x2[7:0];
      A_X2HI:  bus_rdata = rb_x2[15:8];
      default: bus_rdata = 8'h00;
    endcase
  end

  assign ctrl      = ctrl_q;
  assign sw_cfg    = sw_cfg_q;
  assign hw_cfg    = hw_cfg_q;
  assign timer_val = timer_q;
  assign irq_sw    = irq_sw_q;
  assign irq_hw    = irq_hw_q;

  // R5: completion interrupt is a single-cycle pulse
  p_irq_sw_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sw |=> !irq_sw);
  p_irq_hw_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hw |=> !irq_hw);
  // R5: start bit already clear when the interrupt is seen
  p_start_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sw |-> !ctrl_q[CB_START]);
  // R10: one engine, so the two completions never coincide
  p_irq_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_sw && irq_hw));

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int CODE_W  = 10,
  parameter int TIMER_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [3:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              hw_trig,
  output logic              core_req_valid,
  input  logic              core_req_ready,
  output logic [4:0]        core_req_chan,
  input  logic              core_res_valid,
  input  logic [CODE_W-1:0] core_res_code,
  input  logic [CODE_W-1:0] core_res_code2,
  output logic              irq_sw,
  output logic              irq_hw,
  output logic [3:0]        pad_en
);

  logic [7:0]         ctrl;
  logic [6:0]         sw_cfg, hw_cfg;
  logic [TIMER_W-1:0] timer_val;
  logic               sw_go, hw_fire, hw_go;
  logic               busy, done, done_path, done_dual;
  logic [CODE_W-1:0]  done_res, done_res2;

  adc_seq_regs #(.CODE_W(CODE_W), .TIMER_W(TIMER_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .done      (done),
    .done_path (done_path),
    .done_dual (done_dual),
    .done_res  (done_res),
    .done_res2 (done_res2),
    .ctrl      (ctrl),
    .sw_cfg    (sw_cfg),
    .hw_cfg    (hw_cfg),
    .timer_val (timer_val),
    .sw_go     (sw_go),
    .irq_sw    (irq_sw),
    .irq_hw    (irq_hw)
  );

  adc_seq_trigger #(.TIMER_W(TIMER_W)) u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_in  (hw_trig),
    .arm_en   (ctrl[CB_EN] && ctrl[CB_TRIG]),
    .fall_sel (ctrl[CB_FALL]),
    .reload   (timer_val),
    .fire     (hw_fire)
  );

  // double-measurement channels are not offered on the triggered path
  assign hw_go = hw_fire && !is_dual(hw_cfg[4:0]);

  adc_seq_engine #(.CODE_W(CODE_W)) u_eng (
    .clk            (clk),
    .rst_n          (rst_n),
    .abort          (!ctrl[CB_EN]),
    .sw_go          (sw_go),
    .sw_chan        (sw_cfg[4:0]),
    .sw_avg         (sw_cfg[6:5]),
    .hw_go          (hw_go),
    .hw_chan        (hw_cfg[4:0]),
    .hw_avg         (hw_cfg[6:5]),
    .core_req_valid (core_req_valid),
    .core_req_ready (core_req_ready),
    .core_req_chan  (core_req_chan),
    .core_res_valid (core_res_valid),
    .core_res_code  (core_res_code),
    .core_res_code2 (core_res_code2),
    .busy           (busy),
    .done           (done),
    .done_path      (done_path),
    .done_dual      (done_dual),
    .done_res       (done_res),
    .done_res2      (done_res2)
  );

  assign pad_en = ctrl[CB_EN] ? {ctrl[CB_ISNS], ctrl[CB_BUF], ctrl[CB_SUPP], ctrl[CB_PULL]} : 4'b0;

  // R3: an interrupt only follows a cycle with a conversion in progress
  p_irq_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_sw || irq_hw) |-> $past(busy));
  // R2: analog enables are off whenever the block is disabled
  p_pads_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[CB_EN] |-> (pad_en == 4'b0));
  // R9: no request for a double channel on the triggered path
  p_hw_dual_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req_valid && done_path == PATH_HW) |-> !is_dual(core_req_chan));

endmodule

// File: tb/tb_adc_seq_top.sv
module tb_adc_seq_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       hw_trig = 1'b0;
  logic       core_req_valid, core_req_ready;
  logic [4:0] core_req_chan;
  logic       core_res_valid = 1'b0;
  logic [9:0] core_res_code = '0, core_res_code2 = '0;
  logic       irq_sw, irq_hw;
  logic [3:0] pad_en;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // model core controls
  logic model_clr = 1'b0;
  logic stall_en = 1'b0;
  logic max_mode = 1'b0;
  int   seed = 0;
  int   smp_idx = 0;
  int   req_cnt = 0;
  logic pend = 1'b0;
  int   lat = 0;
  logic [4:0] mch = '0;
  logic [4:0] last_ch = '0;
  logic [3:0] rdy_cnt = '0;

  always #2 clk = ~clk;

  adc_seq_top dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_trig(hw_trig),
    .core_req_valid(core_req_valid), .core_req_ready(core_req_ready),
    .core_req_chan(core_req_chan), .core_res_valid(core_res_valid),
    .core_res_code(core_res_code), .core_res_code2(core_res_code2),
    .irq_sw(irq_sw), .irq_hw(irq_hw), .pad_en(pad_en)
  );

  function automatic int code_fn(input int ch, input int i);
    if (max_mode) return 1023;
    return (seed * 37 + ch * 13 + i * 101) % 1024;
  endfunction

  function automatic int code2_fn(input int ch, input int i);
    if (max_mode) return 1023;
    return (seed * 53 + ch * 7 + i * 29 + 500) % 1024;
  endfunction

  function automatic int exp_avg(input int ch, input int n, input bit second);
    int s = 0;
    for (int i = 0; i < n; i++) s += second ? code2_fn(ch, i) : code_fn(ch, i);
    return s / n;
  endfunction

  assign core_req_ready = stall_en ? rdy_cnt[1] : 1'b1;

  always @(posedge clk) begin
    rdy_cnt        <= rdy_cnt + 4'd1;
    core_res_valid <= 1'b0;
    if (model_clr) begin
      smp_idx <= 0;
      req_cnt <= 0;
      pend    <= 1'b0;
    end else begin
      if (core_req_valid && core_req_ready) begin
        pend    <= 1'b1;
        lat     <= 2;
        mch     <= core_req_chan;
        last_ch <= core_req_chan;
        req_cnt <= req_cnt + 1;
      end else if (pend) begin
        if (lat == 0) begin
          pend           <= 1'b0;
          core_res_valid <= 1'b1;
          core_res_code  <= 10'(code_fn(int'(mch), smp_idx));
          core_res_code2 <= 10'(code2_fn(int'(mch), smp_idx));
          smp_idx        <= smp_idx + 1;
        end else begin
          lat <= lat - 1;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    bus_addr = a;
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic rd16(input logic [3:0] lo, output int v);
    int l, h;
    rd(lo, l);
    rd(lo + 4'd1, h);
    v = (h << 8) | l;
  endtask

  task automatic clr_model();
    @(negedge clk); model_clr = 1'b1;
    @(negedge clk); model_clr = 1'b0;
  endtask

  task automatic wait_irq(input bit hw, input int maxc, output int got);
    got = -1;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if (hw ? irq_hw : irq_sw) begin
        got = i;
        break;
      end
    end
  endtask

  task automatic count_irq(input bit hw, input int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (hw ? irq_hw : irq_sw) seen++;
    end
  endtask

  int chs[5] = '{0, 3, 11, 18, 29};
  int v, got, n, prev_x2, prev_sw, prev_hw, e;

  initial begin
    // R1 reset state
    repeat (4) @(negedge clk);
    chk("R1 irq_sw", int'(irq_sw), 0);
    chk("R1 irq_hw", int'(irq_hw), 0);
    chk("R1 pad_en", int'(pad_en), 0);
    chk("R1 req_valid", int'(core_req_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a <= 10; a++) begin
      rd(4'(a), v);
      chk("R1 register", v, 0);
    end

    // R2 control readback and pad enables
    wr(4'h0, 8'hE8);
    rd(4'h0, v); chk("R2 readback", v, 8'hE8);
    chk("R2 pads gated", int'(pad_en), 0);
    wr(4'h0, 8'hE9);
    chk("R2 pads all", int'(pad_en), 4'hF);
    wr(4'h0, 8'h49);
    chk("R2 pads buf+pull", int'(pad_en), 4'h5);
    wr(4'h0, 8'h00);
    rd(4'h0, v); chk("R2 clear", v, 0);
    chk("R2 pads clear", int'(pad_en), 0);

    // R3 R4 R5 R6 R12 software sweep
    prev_x2 = 0;
    for (int avg = 0; avg < 4; avg++) begin
      for (int k = 0; k < 5; k++) begin
        n = (avg == 0) ? 1 : (avg == 1) ? 4 : (avg == 2) ? 8 : 16;
        seed = avg * 10 + k + 1;
        stall_en = k[0];
        clr_model();
        wr(4'h1, {1'b0, 2'(avg), 5'(chs[k])});
        wr(4'h0, 8'h45);
        rd(4'h4, v); chk("R3 busy", v, 1);
        wait_irq(1'b0, 2000, got);
        chk("R5 irq_sw seen", int'(got > 0), 1);
        @(negedge clk);
        chk("R5 irq one cycle", int'(irq_sw), 0);
        chk("R3 request count", req_cnt, n);
        chk("R3 channel", int'(last_ch), chs[k]);
        rd16(4'h5, v); chk("R4 average", v, exp_avg(chs[k], n, 1'b0));
        rd(4'h0, v); chk("R5 start cleared", v, 8'h41);
        rd(4'h4, v); chk("R3 idle after", v, 0);
        rd16(4'h9, v);
        if (chs[k] == 29) begin
          e = exp_avg(chs[k], n, 1'b1);
          chk("R6 second result", v, e);
          prev_x2 = e;
        end else begin
          chk("R6 second unchanged", v, prev_x2);
        end
        if (stall_en) begin
          rd16(4'h5, v); chk("R12 average under stall", v, exp_avg(chs[k], n, 1'b0));
        end
      end
    end

    // R4 full-scale average
    max_mode = 1'b1;
    clr_model();
    wr(4'h1, {1'b0, 2'b11, 5'h01});
    wr(4'h0, 8'h45);
    wait_irq(1'b0, 2000, got);
    rd16(4'h5, v); chk("R4 full scale", v, 1023);
    max_mode = 1'b0;
    prev_sw = 1023;

    // R7 hardware rising edge with timer
    seed = 77;
    clr_model();
    wr(4'h3, 8'd20);
    wr(4'h2, {1'b0, 2'b10, 5'h08});
    wr(4'h0, 8'h43);
    @(negedge clk); hw_trig = 1'b1;
    wait_irq(1'b1, 2000, got);
    chk("R7 timer delay", int'(got > 20), 1);
    rd16(4'h7, v); chk("R7 hw result", v, exp_avg(8, 8, 1'b0));
    prev_hw = v;
    rd16(4'h5, v); chk("R7 sw result untouched", v, prev_sw);
    chk("R7 hw channel", int'(last_ch), 8);
    // R8 falling edge ignored in rising mode
    @(negedge clk); hw_trig = 1'b0;
    count_irq(1'b1, 80, got);
    chk("R8 no fire on falling", got, 0);

    // R7 R8 falling mode
    seed = 91;
    clr_model();
    wr(4'h2, {1'b0, 2'b01, 5'h0C});
    wr(4'h0, 8'h53);
    @(negedge clk); hw_trig = 1'b1;
    count_irq(1'b1, 80, got);
    chk("R8 no fire on rising", got, 0);
    hw_trig = 1'b0;
    wait_irq(1'b1, 2000, got);
    chk("R7 falling fires", int'(got > 20), 1);
    rd16(4'h7, v); chk("R7 falling result", v, exp_avg(12, 4, 1'b0));
    prev_hw = v;

    // R9 double channel on triggered path
    clr_model();
    wr(4'h2, {1'b0, 2'b00, 5'h1E});
    wr(4'h0, 8'h43);
    @(negedge clk); hw_trig = 1'b1;
    count_irq(1'b1, 80, got);
    chk("R9 no irq", got, 0);
    chk("R9 no request", req_cnt, 0);
    rd16(4'h7, v); chk("R9 result unchanged", v, prev_hw);
    wr(4'h0, 8'h00);
    @(negedge clk); hw_trig = 1'b0;

    // R10 starts while busy are ignored
    seed = 5;
    stall_en = 1'b1;
    clr_model();
    wr(4'h3, 8'd0);
    wr(4'h2, {1'b0, 2'b11, 5'h02});
    wr(4'h0, 8'h43);
    @(negedge clk); hw_trig = 1'b1;
    v = 0;
    for (int i = 0; i < 20 && v == 0; i++) begin
      @(negedge clk); rd(4'h4, v);
    end
    chk("R10 hw busy", v, 1);
    wr(4'h0, 8'h47);
    @(negedge clk); hw_trig = 1'b0;
    repeat (4) @(negedge clk);
    hw_trig = 1'b1;
    wait_irq(1'b1, 2000, got);
    chk("R10 hw completes", int'(got > 0), 1);
    rd16(4'h7, v); chk("R10 result intact", v, exp_avg(2, 16, 1'b0));
    count_irq(1'b0, 100, got);
    chk("R10 no sw irq", got, 0);
    chk("R10 request count", req_cnt, 16);
    rd(4'h0, v); chk("R10 start bit stays 0", v, 8'h43);
    wr(4'h0, 8'h00);
    @(negedge clk); hw_trig = 1'b0;
    stall_en = 1'b0;

    // R11 abort mid-conversion
    seed = 33;
    clr_model();
    rd16(4'h5, prev_sw);
    wr(4'h1, {1'b0, 2'b11, 5'h04});
    wr(4'h0, 8'h45);
    repeat (6) @(negedge clk);
    wr(4'h0, 8'h00);
    @(negedge clk);
    rd(4'h4, v); chk("R11 idle after abort", v, 0);
    count_irq(1'b0, 80, got);
    chk("R11 no irq", got, 0);
    rd16(4'h5, v); chk("R11 result unchanged", v, prev_sw);
    chk("R11 pads off", int'(pad_en), 0);
    seed = 44;
    clr_model();
    wr(4'h1, {1'b0, 2'b01, 5'h06});
    wr(4'h0, 8'h45);
    wait_irq(1'b0, 2000, got);
    rd16(4'h5, v); chk("R11 clean after abort", v, exp_avg(6, 4, 1'b0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule